// File: doc/BRIEF.md
# Debug Comms Channel Mailbox

This block carries single 32-bit words between a processor core and an external debugger. It has two mailboxes, one for each direction. The receive mailbox holds a word that the debugger sends to the core. The transmit mailbox holds a word that the core sends to the debugger. Each mailbox has a full flag. The two flags and a fixed version number are read together in one status word. The debugger sends and receives words by polling this status word.

The debugger side is a small addressed register interface, as a scan chain would present it. Address 4 holds the status word. Address 5 is the data port. A debugger read of the data port consumes the transmit word, so the same word is never returned twice. The core side is a coprocessor-style interface: a read strobe that takes the received word, a write strobe that deposits an outgoing word, and both flags.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset, both flags are 0 and both mailbox words are 0. The status word then reads as the version alone, and the data port and `coreRxData` read 0.
- R2: The status word at address 4 has the receive flag in bit 0 and the transmit flag in bit 1. Bits 31..28 hold the constant `VERSION` (default 4'h6). Bits 27..2 are 0.
- R3: A debugger write to address 5 loads the receive word from `dbgWrData`. From the next cycle, `coreRxData` shows that word and the receive flag is 1.
- R4: A `coreRxRd` pulse clears the receive flag on the next cycle. If a debugger write to address 5 happens in the same cycle, the write wins: the flag stays 1 and the new word is held.
- R5: A `coreTxWr` pulse loads the transmit word from `coreTxData` and sets the transmit flag on the next cycle.
- R6: While the debugger reads address 5, `dbgRdData` shows the transmit word. On the next cycle the transmit flag is 0, unless `coreTxWr` is asserted in the same cycle. In that case the flag stays 1 and the new word is held.
- R7: A write into a full mailbox, from either side, replaces the held word and leaves the flag set.
- R8: Debugger writes to address 4 or to any address other than 5 change no state. Reads of any address other than 4 and 5 return 0.
- R9: Reading the status word has no side effect. Repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dbgAddr | input | 5 | Debugger register address |
| dbgWrEn | input | 1 | Debugger write strobe |
| dbgRdEn | input | 1 | Debugger read strobe (side effects only) |
| dbgWrData | input | 32 | Debugger write data |
| dbgRdData | output | 32 | Debugger read data for `dbgAddr` |
| coreRxRd | input | 1 | Core takes the received word |
| coreRxData | output | 32 | Received word |
| coreTxWr | input | 1 | Core deposits an outgoing word |
| coreTxData | input | 32 | Outgoing word from the core |
| coreRxFull | output | 1 | Receive flag |
| coreTxFull | output | 1 | Transmit flag |

## Verification
A wrong flag shows up at the ports one cycle after the strobe that caused it. It appears both in the status word and on the core-side flag outputs. A lost or stale word shows up on the next data-port read or on `coreRxData` in the following cycle. The bench compares every port every cycle, so any divergence is reported in the cycle it first becomes visible. Same-cycle collisions between a core strobe and a debugger access are driven on purpose, because that is where priority errors would hide.

// File: rtl/dbg_mailbox_pkg.sv
package dbg_mailbox_pkg;
  typedef struct packed {
    logic loadRx;
    logic clearRx;
    logic loadTx;
    logic clearTx;
  } mbStrobes_t;
endpackage

// File: rtl/mb_ctrl.sv
module mb_ctrl
  import dbg_mailbox_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_ADDR = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic              dbgWrEn,
  input  logic              dbgRdEn,
  input  logic              coreRxRd,
  input  logic              coreTxWr,
  output mbStrobes_t        strobes,
  output logic              rFlag,
  output logic              wFlag
);
  localparam logic [ADDR_W-1:0] DataSel = ADDR_W'(DATA_ADDR);

  logic hitData;
  assign hitData = (dbgAddr == DataSel);

  always_comb begin
    strobes.loadRx  = dbgWrEn && hitData;
    strobes.clearRx = coreRxRd;
    strobes.loadTx  = coreTxWr;
    strobes.clearTx = dbgRdEn && hitData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rFlag <= 1'b0;
      wFlag <= 1'b0;
    end else begin
      if (strobes.loadRx)       rFlag <= 1'b1;
      else if (strobes.clearRx) rFlag <= 1'b0;
      if (strobes.loadTx)       wFlag <= 1'b1;
      else if (strobes.clearTx) wFlag <= 1'b0;
    end
  end

  AST_RX_SET: assert property (@(posedge clk) disable iff (!rstN)
    (dbgWrEn && dbgAddr == DataSel) |=> rFlag); // R3
  AST_RX_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (coreRxRd && !(dbgWrEn && dbgAddr == DataSel)) |=> !rFlag); // R4
  AST_TX_SET: assert property (@(posedge clk) disable iff (!rstN)
    coreTxWr |=> wFlag); // R5
  AST_TX_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (dbgRdEn && dbgAddr == DataSel && !coreTxWr) |=> !wFlag); // R6
endmodule

// File: rtl/mb_datapath.sv
module mb_datapath
  import dbg_mailbox_pkg::*;
#(
  parameter int            DATA_W    = 32,
  parameter int            ADDR_W    = 5,
  parameter int            VER_W     = 4,
  parameter logic [VER_W-1:0] VERSION = 4'h6,
  parameter int            CTRL_ADDR = 4,
  parameter int            DATA_ADDR = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbStrobes_t        strobes,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic [DATA_W-1:0] dbgWrData,
  input  logic [DATA_W-1:0] coreTxData,
  input  logic              rFlag,
  input  logic              wFlag,
  output logic [DATA_W-1:0] dbgRdData,
  output logic [DATA_W-1:0] coreRxData
);
  localparam int PadW = DATA_W - VER_W - 2;
  localparam logic [ADDR_W-1:0] CtrlSel = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] DataSel = ADDR_W'(DATA_ADDR);

  logic [DATA_W-1:0] rxWord;
  logic [DATA_W-1:0] txWord;
  logic [DATA_W-1:0] statusWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxWord <= '0;
      txWord <= '0;
    end else begin
      if (strobes.loadRx) rxWord <= dbgWrData;
      if (strobes.loadTx) txWord <= coreTxData;
    end
  end

  assign statusWord = {VERSION, {PadW{1'b0}}, wFlag, rFlag};

  always_comb begin
    unique case (dbgAddr)
      CtrlSel: dbgRdData = statusWord;
      DataSel: dbgRdData = txWord;
      default: dbgRdData = '0;
    endcase
  end

  assign coreRxData = rxWord;

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadRx |=> $stable(rxWord)); // R8
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadTx |=> $stable(txWord)); // R6
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import dbg_mailbox_pkg::*;
#(
  parameter int               DATA_W    = 32,
  parameter int               ADDR_W    = 5,
  parameter int               VER_W     = 4,
  parameter logic [VER_W-1:0] VERSION   = 4'h6,
  parameter int               CTRL_ADDR = 4,
  parameter int               DATA_ADDR = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] dbgAddr,
  input  logic              dbgWrEn,
  input  logic              dbgRdEn,
  input  logic [DATA_W-1:0] dbgWrData,
  output logic [DATA_W-1:0] dbgRdData,
  input  logic              coreRxRd,
  output logic [DATA_W-1:0] coreRxData,
  input  logic              coreTxWr,
  input  logic [DATA_W-1:0] coreTxData,
  output logic              coreRxFull,
  output logic              coreTxFull
);
  mbStrobes_t strobes;
  logic rFlag;
  logic wFlag;

  mb_ctrl #(.ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .dbgAddr(dbgAddr), .dbgWrEn(dbgWrEn),
    .dbgRdEn(dbgRdEn), .coreRxRd(coreRxRd), .coreTxWr(coreTxWr),
    .strobes(strobes), .rFlag(rFlag), .wFlag(wFlag)
  );

  mb_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VER_W(VER_W), .VERSION(VERSION),
    .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dbgAddr(dbgAddr),
    .dbgWrData(dbgWrData), .coreTxData(coreTxData), .rFlag(rFlag),
    .wFlag(wFlag), .dbgRdData(dbgRdData), .coreRxData(coreRxData)
  );

  assign coreRxFull = rFlag;
  assign coreTxFull = wFlag;

  AST_NO_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!coreRxRd && !coreTxWr && !dbgRdEn && !(dbgWrEn && dbgAddr == ADDR_W'(DATA_ADDR)))
      |=> ($stable(coreRxFull) && $stable(coreTxFull))); // R8
endmodule

// File: tb/dbg_mailbox_tb.sv
module dbg_mailbox_tb;
  localparam logic [3:0] VER = 4'h6;

  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  dbgAddr;
  logic        dbgWrEn, dbgRdEn, coreRxRd, coreTxWr;
  logic [31:0] dbgWrData, dbgRdData, coreRxData, coreTxData;
  logic        coreRxFull, coreTxFull;

  int checks = 0;
  int fails  = 0;
  logic        refR, refW;
  logic [31:0] refRx, refTx;

  always #10 clk = ~clk;

  dbg_mailbox u_dut (
    .clk(clk), .rstN(rstN), .dbgAddr(dbgAddr), .dbgWrEn(dbgWrEn),
    .dbgRdEn(dbgRdEn), .dbgWrData(dbgWrData), .dbgRdData(dbgRdData),
    .coreRxRd(coreRxRd), .coreRxData(coreRxData), .coreTxWr(coreTxWr),
    .coreTxData(coreTxData), .coreRxFull(coreRxFull), .coreTxFull(coreTxFull)
  );

  function automatic logic [31:0] expRead(logic [4:0] a);
    if (a == 5'd4) return {VER, 26'd0, refW, refR};
    if (a == 5'd5) return refTx;
    return 32'd0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, check combinational view, advance model
  task automatic step(logic [4:0] a, logic we, logic re, logic [31:0] wd,
                      logic crd, logic cwr, logic [31:0] cd);
    @(negedge clk);
    dbgAddr = a; dbgWrEn = we; dbgRdEn = re; dbgWrData = wd;
    coreRxRd = crd; coreTxWr = cwr; coreTxData = cd;
    #1;
    chk((a == 5'd4) ? "R2" : (a == 5'd5) ? "R6" : "R8", dbgRdData, expRead(a));
    chk("R3", coreRxData, refRx);
    chk("R4", {31'd0, coreRxFull}, {31'd0, refR});
    chk("R5", {31'd0, coreTxFull}, {31'd0, refW});
    if (crd) refR = 1'b0;
    if (we && a == 5'd5) begin refR = 1'b1; refRx = wd; end
    if (re && a == 5'd5) refW = 1'b0;
    if (cwr) begin refW = 1'b1; refTx = cd; end
  endtask

  task automatic idle();
    step(5'd4, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rstN = 1'b0;
    dbgAddr = 0; dbgWrEn = 0; dbgRdEn = 0; dbgWrData = 0;
    coreRxRd = 0; coreTxWr = 0; coreTxData = 0;
    refR = 0; refW = 0; refRx = 0; refTx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    dbgAddr = 5'd4; #1;
    chk("R1", dbgRdData, {VER, 28'd0});
    dbgAddr = 5'd5; #1;
    chk("R1", dbgRdData, 32'd0);
    chk("R1", coreRxData, 32'd0);

    // R3 then R7 overwrite, R4 core read
    step(5'd5, 1, 0, 32'hAAAA_0001, 0, 0, 0);
    step(5'd5, 1, 0, 32'hBBBB_0002, 0, 0, 0);
    idle();
    chk("R7", coreRxData, 32'hBBBB_0002);
    step(5'd4, 0, 0, 0, 1, 0, 0);
    idle();
    chk("R4", {31'd0, coreRxFull}, 32'd0);
    // R4 collision: write wins
    step(5'd5, 1, 0, 32'h1111_2222, 1, 0, 0);
    idle();
    chk("R4", {coreRxData[31:1], coreRxFull}, {32'h1111_2222 >> 1, 1'b1});
    // R8 writes to control and other address ignored
    step(5'd4, 1, 0, 32'hFFFF_FFFF, 0, 0, 0);
    step(5'd9, 1, 1, 32'hFFFF_FFFF, 0, 0, 0);
    idle();
    chk("R8", coreRxData, 32'h1111_2222);
    // R5, R7 on transmit, R6 read consumes
    step(5'd4, 0, 0, 0, 0, 1, 32'hC0DE_0001);
    step(5'd4, 0, 0, 0, 0, 1, 32'hC0DE_0002);
    step(5'd5, 0, 1, 0, 0, 0, 0);
    idle();
    chk("R6", {31'd0, coreTxFull}, 32'd0);
    // R6 collision: core write wins
    step(5'd4, 0, 0, 0, 0, 1, 32'h5555_0000);
    step(5'd5, 0, 1, 0, 0, 1, 32'h6666_0000);
    idle();
    chk("R6", {31'd0, coreTxFull}, 32'd1);
    // R9 repeated status reads stable
    step(5'd4, 0, 1, 0, 0, 0, 0);
    step(5'd4, 0, 1, 0, 0, 0, 0);
    chk("R9", dbgRdData, {VER, 26'd0, 1'b1, 1'b1});

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel < 4) ? 5'd5 : (sel < 8) ? 5'd4 : 5'($urandom);
      step(a, ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0), $urandom,
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0), $urandom);
    end
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule